// File: doc/BRIEF.md
# Split-Transaction Command Bus with Per-Core Return Paths

This block connects several processing cores to a set of shared memory targets. Each transfer has two separate phases. In the command phase, a core's request competes for one shared command path. A round-robin arbiter grants one request per cycle, and the request is released as soon as it is granted. The accepted command is labelled with the issuing core's index and carries the core's own transaction tag. It waits in an in-order queue in front of the chosen target until that target takes it.

In the return phase, a target presents a response that carries the core index and tag it received. The block steers the response onto the addressed core's private return bus. Because every core has its own return bus, responses for different cores pass in the same cycle.

Back-pressure comes from two places. Each target's queue has a fixed depth, and a core with too many commands still in flight is held off until responses come back.

Top module: `split_cmd_bus`

## Requirements
- R1: At most one bit of `core_req_ready` is high in any cycle, and it is high only for a core whose `core_req_valid` is high. That cycle is the whole command phase for the core.
- R2: Arbitration is round-robin. After core c is granted, the search for the next grant starts at core c+1, wrapping from NCORE-1 to 0. A core is eligible only if it requests, its target queue is not full, and it is below its outstanding limit.
- R3: A granted command is appended to the queue of the target named by its `core_req_tgt` field. The queue's head appears on `tgt_cmd_valid`/`tgt_cmd_core`/`tgt_cmd_tag`/`tgt_cmd_addr`, where `tgt_cmd_core` is the granted core's index and the tag and address are copied unchanged. Commands leave each queue in grant order when `tgt_cmd_ready` is high.
- R4: Each target queue holds QDEPTH commands. While a queue is full, no request naming that target is granted, and requests to other targets are still served.
- R5: A core that has MAXOUT commands granted but not yet answered on its return bus is not granted again until a response reaches it.
- R6: A target response with `tgt_rsp_valid` high is delivered in the same cycle on `core_rsp_valid`/`core_rsp_tag`/`core_rsp_data` of the core named by `tgt_rsp_core`. Responses for different cores are delivered in the same cycle.
- R7: When several targets respond to the same core in one cycle, the lowest-numbered target is delivered and gets `tgt_rsp_ready`. The others see `tgt_rsp_ready` low and must present the response again.
- R8: After reset all queues are empty, no core has commands outstanding, the arbitration search starts at core 0, and no valid or ready output is high while inputs are idle.
- R9: A command shown at a target's queue head with `tgt_cmd_ready` low stays valid with unchanged core, tag and address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | NCORE | Per-core command request |
| core_req_tgt | input | NCORE*TW | Per-core target index |
| core_req_addr | input | NCORE*AW | Per-core command address |
| core_req_tag | input | NCORE*TAGW | Per-core transaction tag |
| core_req_ready | output | NCORE | Grant; command accepted this cycle |
| tgt_cmd_valid | output | NTGT | Queue head valid per target |
| tgt_cmd_ready | input | NTGT | Target takes the queue head |
| tgt_cmd_core | output | NTGT*CW | Issuing core of queue head |
| tgt_cmd_tag | output | NTGT*TAGW | Tag of queue head |
| tgt_cmd_addr | output | NTGT*AW | Address of queue head |
| tgt_rsp_valid | input | NTGT | Target response present |
| tgt_rsp_ready | output | NTGT | Response delivered this cycle |
| tgt_rsp_core | input | NTGT*CW | Destination core of response |
| tgt_rsp_tag | input | NTGT*TAGW | Tag echoed with response |
| tgt_rsp_data | input | NTGT*DW | Response data |
| core_rsp_valid | output | NCORE | Response on core's return bus |
| core_rsp_tag | output | NCORE*TAGW | Tag on core's return bus |
| core_rsp_data | output | NCORE*DW | Data on core's return bus |

## Verification
The bench builds the block with four cores, two targets, a queue depth of four and an outstanding limit of three. With these values the cores together can have twelve commands in flight, which is more than one queue holds. A stalled target therefore fills its queue while the other target keeps being served. The limit of three is reached within a few cycles once responses are withheld. With two targets, two responses can collide on one core's return bus in the same cycle, and four cores give the round-robin pointer a real wrap-around.

// File: rtl/stb_pkg.sv
`timescale 1ns/1ps
package stb_pkg;
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/stb_rr_arb.sv
`timescale 1ns/1ps
module stb_rr_arb #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gidx,
   output logic          any
);
   logic [IW-1:0] ptr;
   int            i;

   always_comb begin
      gnt  = '0;
      gidx = '0;
      any  = 1'b0;
      i    = 0;
      for (int k = 0; k < N; k++) begin
         i = (int'(ptr) + k) % N;
         if (!any && req[i]) begin
            any    = 1'b1;
            gnt[i] = 1'b1;
            gidx   = IW'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else if (any) ptr <= (int'(gidx) == N-1) ? '0 : gidx + 1'b1;
   end
endmodule

// File: rtl/stb_cmd_fifo.sv
`timescale 1ns/1ps
module stb_cmd_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic         full,
   output logic         nonempty,
   output logic [W-1:0] dout
);
   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold;
         logic         vld;
         always_ff @(posedge clk) begin
            if (!rst_n) vld <= 1'b0;
            else if (push) vld <= 1'b1;
            else if (pop) vld <= 1'b0;
         end
         always_ff @(posedge clk) if (push) hold <= din;
         assign full     = vld;
         assign nonempty = vld;
         assign dout     = hold;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CNW = $clog2(DEPTH + 1);
         logic [W-1:0]   mem [DEPTH];
         logic [PW-1:0]  wp, rp;
         logic [CNW-1:0] cnt;
         logic           do_pop, do_push;
         assign do_pop  = pop && (cnt != '0);
         assign do_push = push && (int'(cnt) != DEPTH);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else begin
               if (do_push) wp <= (int'(wp) == DEPTH-1) ? '0 : wp + 1'b1;
               if (do_pop)  rp <= (int'(rp) == DEPTH-1) ? '0 : rp + 1'b1;
               cnt <= cnt + CNW'(do_push) - CNW'(do_pop);
            end
         end
         always_ff @(posedge clk) if (do_push) mem[wp] <= din;
         assign full     = (int'(cnt) == DEPTH);
         assign nonempty = (cnt != '0);
         assign dout     = mem[rp];
      end
   endgenerate
endmodule

// File: rtl/stb_credit.sv
`timescale 1ns/1ps
module stb_credit #(
   parameter int MAXOUT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic at_limit
);
   localparam int CNW = $clog2(MAXOUT + 1);
   logic [CNW-1:0] cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else begin
         case ({inc, dec})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
   assign at_limit = (int'(cnt) == MAXOUT);
endmodule

// File: rtl/split_cmd_bus.sv
`timescale 1ns/1ps
module split_cmd_bus #(
   parameter int NCORE  = 4,
   parameter int NTGT   = 2,
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter int TAGW   = 4,
   parameter int QDEPTH = 4,
   parameter int MAXOUT = 3,
   localparam int CW = stb_pkg::idx_w(NCORE),
   localparam int TW = stb_pkg::idx_w(NTGT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCORE-1:0]      core_req_valid,
   input  logic [NCORE*TW-1:0]   core_req_tgt,
   input  logic [NCORE*AW-1:0]   core_req_addr,
   input  logic [NCORE*TAGW-1:0] core_req_tag,
   output logic [NCORE-1:0]      core_req_ready,
   output logic [NTGT-1:0]       tgt_cmd_valid,
   input  logic [NTGT-1:0]       tgt_cmd_ready,
   output logic [NTGT*CW-1:0]    tgt_cmd_core,
   output logic [NTGT*TAGW-1:0]  tgt_cmd_tag,
   output logic [NTGT*AW-1:0]    tgt_cmd_addr,
   input  logic [NTGT-1:0]       tgt_rsp_valid,
   output logic [NTGT-1:0]       tgt_rsp_ready,
   input  logic [NTGT*CW-1:0]    tgt_rsp_core,
   input  logic [NTGT*TAGW-1:0]  tgt_rsp_tag,
   input  logic [NTGT*DW-1:0]    tgt_rsp_data,
   output logic [NCORE-1:0]      core_rsp_valid,
   output logic [NCORE*TAGW-1:0] core_rsp_tag,
   output logic [NCORE*DW-1:0]   core_rsp_data
);
   localparam int QW = CW + TAGW + AW;

   if (NCORE < 2) begin : g_bad_core
      $error("split_cmd_bus: NCORE must be at least 2");
   end
   if (NTGT < 1) begin : g_bad_tgt
      $error("split_cmd_bus: NTGT must be at least 1");
   end
   if (QDEPTH < 1 || MAXOUT < 1) begin : g_bad_depth
      $error("split_cmd_bus: QDEPTH and MAXOUT must be positive");
   end

   logic [NCORE-1:0] elig, gnt, lim;
   logic [CW-1:0]    gidx;
   logic             gany;
   logic [NTGT-1:0]  q_full;
   logic [TW-1:0]    gtgt;
   logic [QW-1:0]    qdin;
   logic [NCORE-1:0][NTGT-1:0] win;

   // eligibility: request present, target queue has room, core below limit
   generate
      for (genvar c = 0; c < NCORE; c++) begin : g_core
         logic [TW-1:0] ct;
         assign ct = core_req_tgt[c*TW +: TW];
         assign elig[c] = core_req_valid[c] && (int'(ct) < NTGT)
                          && !q_full[ct] && !lim[c];
         stb_credit #(.MAXOUT(MAXOUT)) u_credit (
            .clk(clk), .rst_n(rst_n),
            .inc(gnt[c]), .dec(core_rsp_valid[c]), .at_limit(lim[c]));
      end
   endgenerate

   stb_rr_arb #(.N(NCORE), .IW(CW)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(elig), .gnt(gnt), .gidx(gidx), .any(gany));

   assign core_req_ready = gnt;
   assign gtgt = core_req_tgt[int'(gidx)*TW +: TW];
   assign qdin = {gidx, core_req_tag[int'(gidx)*TAGW +: TAGW],
                  core_req_addr[int'(gidx)*AW +: AW]};

   // per-target in-order command queues
   generate
      for (genvar t = 0; t < NTGT; t++) begin : g_tgt
         logic [QW-1:0] qout;
         stb_cmd_fifo #(.W(QW), .DEPTH(QDEPTH)) u_q (
            .clk(clk), .rst_n(rst_n),
            .push(gany && (int'(gtgt) == t)), .din(qdin),
            .pop(tgt_cmd_ready[t]), .full(q_full[t]),
            .nonempty(tgt_cmd_valid[t]), .dout(qout));
         assign tgt_cmd_core[t*CW +: CW]     = qout[QW-1 -: CW];
         assign tgt_cmd_tag[t*TAGW +: TAGW]  = qout[AW +: TAGW];
         assign tgt_cmd_addr[t*AW +: AW]     = qout[AW-1:0];
      end
   endgenerate

   // response steering: one return bus per core, lowest target wins
   generate
      for (genvar c = 0; c < NCORE; c++) begin : g_ret
         logic [NTGT-1:0] hit;
         logic [TAGW-1:0] tg;
         logic [DW-1:0]   dt;
         for (genvar t = 0; t < NTGT; t++) begin : g_hit
            assign hit[t] = tgt_rsp_valid[t] &&
                            (int'(tgt_rsp_core[t*CW +: CW]) == c);
         end
         assign win[c] = hit & (~hit + 1'b1);
         always_comb begin
            tg = '0;
            dt = '0;
            for (int t = 0; t < NTGT; t++) begin
               if (win[c][t]) begin
                  tg = tg | tgt_rsp_tag[t*TAGW +: TAGW];
                  dt = dt | tgt_rsp_data[t*DW +: DW];
               end
            end
         end
         assign core_rsp_valid[c]             = |hit;
         assign core_rsp_tag[c*TAGW +: TAGW]  = tg;
         assign core_rsp_data[c*DW +: DW]     = dt;
      end
   endgenerate

   always_comb begin
      tgt_rsp_ready = '0;
      for (int c = 0; c < NCORE; c++) tgt_rsp_ready = tgt_rsp_ready | win[c];
   end
endmodule

// File: rtl/split_cmd_bus_chk.sv
`timescale 1ns/1ps
module split_cmd_bus_chk #(
   parameter int NCORE  = 4,
   parameter int NTGT   = 2,
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter int TAGW   = 4,
   parameter int QDEPTH = 4,
   parameter int MAXOUT = 3,
   parameter int CW     = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NCORE-1:0]      core_req_valid,
   input logic [NCORE-1:0]      core_req_ready,
   input logic [NTGT-1:0]       tgt_cmd_valid,
   input logic [NTGT-1:0]       tgt_cmd_ready,
   input logic [NTGT*CW-1:0]    tgt_cmd_core,
   input logic [NTGT*TAGW-1:0]  tgt_cmd_tag,
   input logic [NTGT*AW-1:0]    tgt_cmd_addr,
   input logic [NTGT-1:0]       tgt_rsp_valid,
   input logic [NTGT-1:0]       tgt_rsp_ready,
   input logic [NTGT*CW-1:0]    tgt_rsp_core,
   input logic [NCORE-1:0]      core_rsp_valid
);
   int               ocnt [NCORE];
   logic [NCORE-1:0] src_any;

   always_ff @(posedge clk) begin
      for (int c = 0; c < NCORE; c++) begin
         if (!rst_n) ocnt[c] <= 0;
         else ocnt[c] <= ocnt[c] + int'(core_req_ready[c]) - int'(core_rsp_valid[c]);
      end
   end

   always_comb begin
      src_any = '0;
      for (int t = 0; t < NTGT; t++)
         if (tgt_rsp_valid[t]) src_any[tgt_rsp_core[t*CW +: CW]] = 1'b1;
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_req_ready)); // R1
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req_ready & ~core_req_valid) == '0); // R1

   generate
      for (genvar c = 0; c < NCORE; c++) begin : g_c
         AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (ocnt[c] >= MAXOUT) |-> !core_req_ready[c]); // R5
         AST_RSP_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            core_rsp_valid[c] |-> src_any[c]); // R6
      end
      for (genvar t = 0; t < NTGT; t++) begin : g_t
         AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_cmd_valid[t] && !tgt_cmd_ready[t]) |=>
            (tgt_cmd_valid[t] && $stable(tgt_cmd_core[t*CW +: CW]) &&
             $stable(tgt_cmd_tag[t*TAGW +: TAGW]) &&
             $stable(tgt_cmd_addr[t*AW +: AW]))); // R9
         AST_RSP_ACK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            tgt_rsp_ready[t] |-> tgt_rsp_valid[t]); // R7
      end
   endgenerate
endmodule

bind split_cmd_bus split_cmd_bus_chk #(
   .NCORE(NCORE), .NTGT(NTGT), .AW(AW), .DW(DW), .TAGW(TAGW),
   .QDEPTH(QDEPTH), .MAXOUT(MAXOUT), .CW(CW)
) u_chk (.*);

// File: tb/split_cmd_bus_test.sv
`timescale 1ns/1ps
module split_cmd_bus_test;
   localparam int NC = 4, NT = 2, AW = 8, DW = 16, TAGW = 4, QD = 4, MO = 3;
   localparam int CW = 2, TW = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NC-1:0]      core_req_valid, core_req_ready, core_rsp_valid;
   logic [NC*TW-1:0]   core_req_tgt;
   logic [NC*AW-1:0]   core_req_addr;
   logic [NC*TAGW-1:0] core_req_tag, core_rsp_tag;
   logic [NC*DW-1:0]   core_rsp_data;
   logic [NT-1:0]      tgt_cmd_valid, tgt_cmd_ready, tgt_rsp_valid, tgt_rsp_ready;
   logic [NT*CW-1:0]   tgt_cmd_core, tgt_rsp_core;
   logic [NT*TAGW-1:0] tgt_cmd_tag, tgt_rsp_tag;
   logic [NT*AW-1:0]   tgt_cmd_addr;
   logic [NT*DW-1:0]   tgt_rsp_data;

   split_cmd_bus #(.NCORE(NC), .NTGT(NT), .AW(AW), .DW(DW), .TAGW(TAGW),
                   .QDEPTH(QD), .MAXOUT(MO)) uut (.*);

   typedef struct { int core; int tag; int addr; } cmd_t;
   cmd_t mq [NT][$];
   cmd_t rq [NT][$];
   int   mcnt [NC];
   int   mptr;
   int   rv [NC], rt [NC], ra [NC], rtag [NC], tseq [NC];
   int   p_req, p_cmdrdy [NT], p_rsp [NT], fix_tgt;
   int   total = 0, bad = 0;
   int   seen_full = 0, seen_lim = 0, seen_clash = 0, seen_hold = 0, seen_par = 0;
   bit   prev_hold [NT];
   int   prev_core [NT], prev_tag [NT], prev_addr [NT];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int rdata(input cmd_t c, input int t);
      return (c.addr * 5 + c.tag * 3 + t * 17) & 16'hFFFF;
   endfunction

   task automatic step();
      int  eg, nrsp;
      bit  el;
      logic [NC-1:0] exp_rv;
      logic [NT-1:0] exp_rr;
      int  wt [NC];
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
         if (rv[c] == 0 && $urandom_range(99) < p_req) begin
            rv[c] = 1;
            rt[c] = (fix_tgt >= 0) ? fix_tgt : $urandom_range(NT-1);
            ra[c] = $urandom_range(255);
            rtag[c] = tseq[c];
            tseq[c] = (tseq[c] + 1) % 16;
         end
         core_req_valid[c] = rv[c][0];
         core_req_tgt[c*TW +: TW] = TW'(rt[c]);
         core_req_addr[c*AW +: AW] = AW'(ra[c]);
         core_req_tag[c*TAGW +: TAGW] = TAGW'(rtag[c]);
      end
      for (int t = 0; t < NT; t++) begin
         tgt_cmd_ready[t] = ($urandom_range(99) < p_cmdrdy[t]);
         tgt_rsp_valid[t] = (rq[t].size() > 0) && ($urandom_range(99) < p_rsp[t]);
         if (rq[t].size() > 0) begin
            tgt_rsp_core[t*CW +: CW] = CW'(rq[t][0].core);
            tgt_rsp_tag[t*TAGW +: TAGW] = TAGW'(rq[t][0].tag);
            tgt_rsp_data[t*DW +: DW] = DW'(rdata(rq[t][0], t));
         end else begin
            tgt_rsp_core[t*CW +: CW] = '0;
            tgt_rsp_tag[t*TAGW +: TAGW] = '0;
            tgt_rsp_data[t*DW +: DW] = '0;
         end
      end
      #1;
      // expected grant from the reference model
      eg = -1;
      for (int k = 0; k < NC; k++) begin
         int i;
         i = (mptr + k) % NC;
         el = (rv[i] != 0) && (mq[rt[i]].size() < QD) && (mcnt[i] < MO);
         if (eg < 0 && el) eg = i;
      end
      chk(core_req_ready == ((eg >= 0) ? (NC'(1) << eg) : '0), "R2 grant",
          int'(core_req_ready), (eg >= 0) ? (1 << eg) : 0);
      chk($countones(core_req_ready) <= 1 && (core_req_ready & ~core_req_valid) == '0,
          "R1 single grant", int'(core_req_ready), int'(core_req_valid));
      for (int c = 0; c < NC; c++) begin
         if (rv[c] != 0 && mq[rt[c]].size() == QD) begin
            seen_full++;
            chk(!core_req_ready[c], "R4 full queue blocks", int'(core_req_ready[c]), 0);
         end
         if (rv[c] != 0 && mcnt[c] == MO) begin
            seen_lim++;
            chk(!core_req_ready[c], "R5 limit blocks", int'(core_req_ready[c]), 0);
         end
      end
      // command queue heads
      for (int t = 0; t < NT; t++) begin
         bit ev;
         ev = mq[t].size() > 0;
         chk(tgt_cmd_valid[t] == ev, "R3 head valid", int'(tgt_cmd_valid[t]), int'(ev));
         if (ev) begin
            chk(int'(tgt_cmd_core[t*CW +: CW]) == mq[t][0].core &&
                int'(tgt_cmd_tag[t*TAGW +: TAGW]) == mq[t][0].tag &&
                int'(tgt_cmd_addr[t*AW +: AW]) == mq[t][0].addr, "R3 head fields",
                int'(tgt_cmd_addr[t*AW +: AW]), mq[t][0].addr);
         end
         if (prev_hold[t]) begin
            seen_hold++;
            chk(tgt_cmd_valid[t] && int'(tgt_cmd_core[t*CW +: CW]) == prev_core[t] &&
                int'(tgt_cmd_tag[t*TAGW +: TAGW]) == prev_tag[t] &&
                int'(tgt_cmd_addr[t*AW +: AW]) == prev_addr[t], "R9 held command",
                int'(tgt_cmd_addr[t*AW +: AW]), prev_addr[t]);
         end
         prev_hold[t] = tgt_cmd_valid[t] && !tgt_cmd_ready[t];
         prev_core[t] = int'(tgt_cmd_core[t*CW +: CW]);
         prev_tag[t]  = int'(tgt_cmd_tag[t*TAGW +: TAGW]);
         prev_addr[t] = int'(tgt_cmd_addr[t*AW +: AW]);
      end
      // response steering
      exp_rv = '0;
      exp_rr = '0;
      nrsp = 0;
      for (int c = 0; c < NC; c++) begin
         int hits;
         wt[c] = -1;
         hits = 0;
         for (int t = 0; t < NT; t++)
            if (tgt_rsp_valid[t] && rq[t][0].core == c) begin
               hits++;
               if (wt[c] < 0) wt[c] = t;
            end
         if (hits > 1) seen_clash++;
         if (wt[c] >= 0) begin
            exp_rv[c] = 1'b1;
            exp_rr[wt[c]] = 1'b1;
            nrsp++;
         end
      end
      if (nrsp > 1) seen_par++;
      chk(core_rsp_valid == exp_rv, "R6 return valid", int'(core_rsp_valid), int'(exp_rv));
      chk(tgt_rsp_ready == exp_rr, "R7 target ack", int'(tgt_rsp_ready), int'(exp_rr));
      for (int c = 0; c < NC; c++)
         if (wt[c] >= 0)
            chk(int'(core_rsp_tag[c*TAGW +: TAGW]) == rq[wt[c]][0].tag &&
                int'(core_rsp_data[c*DW +: DW]) == rdata(rq[wt[c]][0], wt[c]),
                "R6 return payload", int'(core_rsp_data[c*DW +: DW]),
                rdata(rq[wt[c]][0], wt[c]));
      // advance the model to the coming edge
      for (int c = 0; c < NC; c++) if (exp_rv[c]) mcnt[c]--;
      for (int t = 0; t < NT; t++) begin
         if (exp_rr[t]) void'(rq[t].pop_front());
         if (mq[t].size() > 0 && tgt_cmd_ready[t]) rq[t].push_back(mq[t].pop_front());
      end
      if (eg >= 0) begin
         cmd_t n;
         n.core = eg; n.tag = rtag[eg]; n.addr = ra[eg];
         mq[rt[eg]].push_back(n);
         mcnt[eg]++;
         mptr = (eg + 1) % NC;
         rv[eg] = 0;
      end
   endtask

   task automatic phase(input int n, input int pr, input int c0, input int c1,
                        input int r0, input int r1, input int ft);
      p_req = pr; p_cmdrdy[0] = c0; p_cmdrdy[1] = c1;
      p_rsp[0] = r0; p_rsp[1] = r1; fix_tgt = ft;
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      #(5.0 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int busy;
      core_req_valid = '0; core_req_tgt = '0; core_req_addr = '0; core_req_tag = '0;
      tgt_cmd_ready = '0; tgt_rsp_valid = '0; tgt_rsp_core = '0;
      tgt_rsp_tag = '0; tgt_rsp_data = '0;
      mptr = 0;
      for (int c = 0; c < NC; c++) begin
         mcnt[c] = 0; rv[c] = 0; rt[c] = 0; ra[c] = 0; rtag[c] = 0; tseq[c] = 0;
      end
      for (int t = 0; t < NT; t++) prev_hold[t] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk(core_req_ready == '0 && tgt_cmd_valid == '0 && core_rsp_valid == '0 &&
          tgt_rsp_ready == '0, "R8 reset outputs",
          int'({core_req_ready, tgt_cmd_valid, core_rsp_valid}), 0);
      rst_n = 1'b1;
      // R8: all cores request at once; model pointer starts at core 0
      phase(20, 100, 100, 100, 100, 100, -1);
      phase(2000, 50, 60, 60, 50, 50, -1);
      // R4: target 0 stalls while target 1 keeps flowing
      phase(60, 90, 0, 100, 0, 80, -1);
      phase(200, 50, 70, 70, 60, 60, -1);
      // R5: targets accept commands but withhold responses
      phase(40, 100, 100, 100, 0, 0, -1);
      // R7: both targets busy with returns
      phase(1500, 70, 90, 90, 90, 90, -1);
      phase(300, 80, 80, 80, 40, 40, 1);
      // drain
      p_req = 0;
      busy = 1;
      for (int i = 0; i < 3000 && busy != 0; i++) begin
         phase(1, 0, 100, 100, 100, 100, -1);
         busy = 0;
         for (int c = 0; c < NC; c++) busy += mcnt[c] + rv[c];
      end
      chk(busy == 0, "R5 all responses returned", busy, 0);
      chk(seen_full > 0, "R4 full queue reached", seen_full, 1);
      chk(seen_lim > 0, "R5 limit reached", seen_lim, 1);
      chk(seen_clash > 0, "R7 same-core collision seen", seen_clash, 1);
      chk(seen_par > 0, "R6 parallel returns seen", seen_par, 1);
      chk(seen_hold > 0, "R9 stalled head seen", seen_hold, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule